// File: doc/BRIEF.md
# Time-Multiplexed 5x5 Convolution Kernel

This block produces one output pixel of a two-dimensional 5x5 convolution, for example a Gaussian smoothing mask. An upstream stage presents a full 25-pixel neighbourhood as one wide word with a valid/ready handshake. The block stores the window and multiplies every pixel by its own mask weight. It adds all 25 products and emits the scaled and saturated result with a one-cycle valid strobe.

The arithmetic uses three multiply-accumulate lanes that run side by side. Each lane is reused over nine multiplex steps and reads its weights from a small constant table of its own. The first lane covers positions 0 to 8, the second covers 9 to 16 and the third covers 17 to 24. On the last step the two shorter lanes multiply by zero. Pixel width, weight width, fractional bits and the weight set are all fixed when the design is elaborated. The default weight set is the binomial 5x5 Gaussian, which sums to 256 and uses 8 fractional bits.

A new window can be taken during the final step of the previous one, so the block sustains one output every nine cycles.

Top module: `conv5x5_tdm`

## Requirements
- R1: A window taken on a clock edge with `win_valid` and `win_ready` both high produces `out_pix` = min(2^PIX_W-1, (sum over k of pixel[k]*weight[k]) >> FRAC_W). Pixel k sits at `win_pix[k*PIX_W +: PIX_W]` and weight k at `COEFS[k*COEF_W +: COEF_W]`, with k = 5*row + column.
- R2: After reset, and whenever no window is being processed, `win_ready` is high.
- R3: In the 8 cycles after an accepting edge (multiplex steps 0 to 7), `win_ready` is low. A window offered in those cycles is not taken and does not change the running result.
- R4: `out_valid` is high for exactly one cycle. That cycle is the tenth after the accepting edge, one cycle after step 8, and `out_pix` holds the result during it.
- R5: `win_ready` is high during step 8 (the ninth cycle after acceptance). A window taken then starts a new computation whose result does not depend on the previous window.
- R6: A scaled sum above 2^PIX_W-1 yields exactly 2^PIX_W-1. A scaled sum at or below that value is passed through unchanged.
- R7: The accumulators are wide enough that all 25 pixels and weights at their maximum values give a correct sum with no wrap-around.
- R8: A synchronous reset `rst` clears `out_valid` and abandons a computation in progress, so no result is emitted for it. After reset `win_ready` is high.
- R9: All 25 positions contribute with their own weight, including the positions where one lane's share ends and the next lane's begins (8/9 and 16/17) and the last position, 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | A 25-pixel window is offered |
| win_ready | output | 1 | The block can take a window this cycle |
| win_pix | input | 25*PIX_W | Window pixels, position k at bits k*PIX_W upward |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_pix | output | PIX_W | Scaled, saturated convolution result |

## Verification
Relative to the accepting clock edge, `win_ready` is due low in cycles 1 to 8 and high in cycle 9. The result and `out_valid` are due in cycle 10, and `out_valid` must be low again in cycle 11. The bench drives inputs on falling edges and counts falling edges from the accepting edge, so every check samples in the exact cycle its value is due. For a back-to-back window, the second result is due nine cycles after the first. The checker module tracks the same cycle count with its own counter and compares the handshake and strobe against it on every edge.

// File: rtl/conv5x5_pkg.sv
package conv5x5_pkg;

   localparam int N_TAPS  = 25;
   localparam int N_LANES = 3;

   // products handled by a lane: lane 0 takes the remainder
   function automatic int lane_len(input int lane);
      return (N_TAPS - lane + N_LANES - 1) / N_LANES;
   endfunction

   // first window position handled by a lane
   function automatic int lane_base(input int lane);
      int b;
      b = 0;
      for (int i = 0; i < lane; i++) b += lane_len(i);
      return b;
   endfunction

   localparam int N_STEPS = lane_len(0);

   function automatic int binom5(input int i);
      case (i)
         0, 4:    return 1;
         1, 3:    return 4;
         default: return 6;
      endcase
   endfunction

   // default 5x5 binomial Gaussian, weights sum to 256
   function automatic logic [N_TAPS*8-1:0] gauss_coefs();
      logic [N_TAPS*8-1:0] v;
      v = '0;
      for (int r = 0; r < 5; r++)
         for (int c = 0; c < 5; c++)
            v[(r*5+c)*8 +: 8] = 8'(binom5(r) * binom5(c));
      return v;
   endfunction

endpackage

// File: rtl/conv_coef_rom.sv
module conv_coef_rom #(
   parameter int LANE   = 0,
   parameter int COEF_W = 8,
   parameter int STEP_W = 4,
   parameter logic [conv5x5_pkg::N_TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic [STEP_W-1:0] step,
   output logic [COEF_W-1:0] coef
);
   localparam int BASE = conv5x5_pkg::lane_base(LANE);
   localparam int LEN  = conv5x5_pkg::lane_len(LANE);

   always_comb begin
      coef = '0;
      if (int'(step) < LEN)
         coef = COEFS[(BASE + int'(step))*COEF_W +: COEF_W];
   end
endmodule

// File: rtl/conv_mac_lane.sv
module conv_mac_lane #(
   parameter int LANE   = 0,
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int ACC_W  = 21,
   parameter int STEP_W = 4,
   parameter logic [conv5x5_pkg::N_TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  en,
   input  logic                                  first,
   input  logic [STEP_W-1:0]                     step,
   input  logic [conv5x5_pkg::N_TAPS*PIX_W-1:0]  window,
   output logic [ACC_W-1:0]                      acc
);
   localparam int BASE  = conv5x5_pkg::lane_base(LANE);
   localparam int LEN   = conv5x5_pkg::lane_len(LANE);
   localparam int PROD_W = PIX_W + COEF_W;

   logic [COEF_W-1:0] coef;
   logic [PIX_W-1:0]  pix;
   logic [PROD_W-1:0] prod;

   conv_coef_rom #(
      .LANE(LANE), .COEF_W(COEF_W), .STEP_W(STEP_W), .COEFS(COEFS)
   ) u_rom (
      .step(step),
      .coef(coef)
   );

   always_comb begin
      pix = '0;
      if (int'(step) < LEN)
         pix = window[(BASE + int'(step))*PIX_W +: PIX_W];
   end

   assign prod = PROD_W'(pix) * PROD_W'(coef);

   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else if (en)
         acc <= first ? ACC_W'(prod) : acc + ACC_W'(prod);
   end
endmodule

// File: rtl/conv_step_ctrl.sv
module conv_step_ctrl #(
   parameter int STEP_W = 4,
   parameter int LAST   = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              win_valid,
   output logic              win_ready,
   output logic              accept,
   output logic              busy,
   output logic              first,
   output logic [STEP_W-1:0] step,
   output logic              done
);
   logic at_last;

   assign at_last   = busy && (int'(step) == LAST);
   assign win_ready = !busy || at_last;
   assign accept    = win_valid && win_ready;
   assign first     = busy && (step == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= at_last;
         if (accept) begin
            busy <= 1'b1;
            step <= '0;
         end else if (at_last) begin
            busy <= 1'b0;
         end else if (busy) begin
            step <= step + 1'b1;
         end
      end
   end
endmodule

// File: rtl/conv5x5_tdm.sv
module conv5x5_tdm #(
   parameter int PIX_W  = 8,
   parameter int COEF_W = 8,
   parameter int FRAC_W = 8,
   parameter logic [conv5x5_pkg::N_TAPS*COEF_W-1:0] COEFS = conv5x5_pkg::gauss_coefs()
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 win_valid,
   output logic                                 win_ready,
   input  logic [conv5x5_pkg::N_TAPS*PIX_W-1:0] win_pix,
   output logic                                 out_valid,
   output logic [PIX_W-1:0]                     out_pix
);
   import conv5x5_pkg::*;

   localparam int GROWTH = $clog2(N_TAPS);
   localparam int ACC_W  = PIX_W + COEF_W + GROWTH;
   localparam int STEP_W = $clog2(N_STEPS);

   if (PIX_W < 1 || COEF_W < 1) begin : g_bad_width
      $error("conv5x5_tdm: PIX_W and COEF_W must be positive");
   end
   if (FRAC_W < 0 || FRAC_W > PIX_W + COEF_W) begin : g_bad_frac
      $error("conv5x5_tdm: FRAC_W out of range");
   end

   logic              accept, busy, first;
   logic [STEP_W-1:0] step;
   logic [N_TAPS*PIX_W-1:0] win_q;
   logic [ACC_W-1:0]  lane_acc [N_LANES];
   logic [ACC_W-1:0]  total, scaled;

   conv_step_ctrl #(.STEP_W(STEP_W), .LAST(N_STEPS-1)) u_ctrl (
      .clk(clk), .rst(rst), .win_valid(win_valid), .win_ready(win_ready),
      .accept(accept), .busy(busy), .first(first), .step(step),
      .done(out_valid)
   );

   always_ff @(posedge clk) begin
      if (accept) win_q <= win_pix;
   end

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      conv_mac_lane #(
         .LANE(l), .PIX_W(PIX_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
         .STEP_W(STEP_W), .COEFS(COEFS)
      ) u_lane (
         .clk(clk), .rst(rst), .en(busy), .first(first), .step(step),
         .window(win_q), .acc(lane_acc[l])
      );
   end

   always_comb begin
      total = '0;
      for (int l = 0; l < N_LANES; l++) total = total + lane_acc[l];
   end

   assign scaled  = total >> FRAC_W;
   assign out_pix = (scaled > ACC_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}}
                                                     : scaled[PIX_W-1:0];
endmodule

// File: rtl/conv5x5_tdm_chk.sv
module conv5x5_tdm_chk (
   input logic clk,
   input logic rst,
   input logic win_valid,
   input logic win_ready,
   input logic out_valid
);
   logic [3:0] cnt;
   logic       due_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         due_q <= 1'b0;
      end else begin
         due_q <= (cnt == 4'd9);
         if (win_valid && win_ready) cnt <= 4'd1;
         else if (cnt == 4'd9)       cnt <= 4'd0;
         else if (cnt != 4'd0)       cnt <= cnt + 4'd1;
      end
   end

   AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
      (cnt == 4'd0) |-> win_ready);                                  // R2
   AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
      (cnt >= 4'd1 && cnt <= 4'd8) |-> !win_ready);                  // R3
   AST_READY_STEP8: assert property (@(posedge clk) disable iff (rst)
      (cnt == 4'd9) |-> win_ready);                                  // R5
   AST_VALID_TIMING: assert property (@(posedge clk) disable iff (rst)
      out_valid == due_q);                                           // R4
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);                                     // R4
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $fell(rst) |-> (!out_valid && win_ready));                     // R8
endmodule

bind conv5x5_tdm conv5x5_tdm_chk u_chk (
   .clk(clk), .rst(rst), .win_valid(win_valid),
   .win_ready(win_ready), .out_valid(out_valid)
);

// File: tb/sim_conv5x5_tdm.sv
`timescale 1ns/1ps
module sim_conv5x5_tdm;
   localparam int W = 200;

   typedef struct packed {
      logic [W-1:0] pix;
      logic [7:0]   e0;
      logic [7:0]   e1;
   } vec_t;

   function automatic logic [W-1:0] ramp_coefs();
      logic [W-1:0] v;
      v = '0;
      for (int k = 0; k < 25; k++) v[k*8 +: 8] = 8'(k + 1);
      return v;
   endfunction

   function automatic logic [W-1:0] one(input int k, input int val);
      return W'(val) << (k*8);
   endfunction

   localparam logic [W-1:0] RAMP = ramp_coefs();
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{ {25{8'd0}},   8'd0,   8'd0   },   // zeros
      '{ {25{8'd255}}, 8'd255, 8'd255 },   // full scale, R7
      '{ {25{8'd100}}, 8'd100, 8'd255 },
      '{ W'(8'd200) << 96,  8'd28, 8'd255 },  // centre
      '{ W'(8'd255),        8'd0,  8'd255 },  // corner k0
      '{ W'(8'd128) << 56,  8'd12, 8'd255 },  // k7
      '{ {{10{8'd0}}, {5{8'd255}}, {10{8'd0}}}, 8'd95, 8'd255 },
      '{ W'(8'd10) << 192,  8'd0,  8'd250 },  // k24 below limit
      '{ W'(8'd11) << 192,  8'd0,  8'd255 },  // k24 just over
      '{ W'(8'd1) << 64,    8'd0,  8'd9   },  // k8
      '{ W'(8'd1) << 72,    8'd0,  8'd10  },  // k9
      '{ W'(8'd1) << 128,   8'd0,  8'd17  },  // k16
      '{ W'(8'd1) << 136,   8'd0,  8'd18  },  // k17
      '{ (W'(8'd4) << 192) | W'(8'd3), 8'd0, 8'd103 }
   };

   logic         clk = 0;
   logic         rst = 1;
   logic         win_valid = 0;
   logic [W-1:0] win_pix = '0;
   logic         r0, r1, ov0, ov1;
   logic [7:0]   op0, op1;
   int           checks = 0, errors = 0, cyc = 0;
   bit           finished = 0;

   always #2 clk = ~clk;

   conv5x5_tdm u0 (
      .clk(clk), .rst(rst), .win_valid(win_valid), .win_ready(r0),
      .win_pix(win_pix), .out_valid(ov0), .out_pix(op0)
   );
   conv5x5_tdm #(.FRAC_W(0), .COEFS(RAMP)) u1 (
      .clk(clk), .rst(rst), .win_valid(win_valid), .win_ready(r1),
      .win_pix(win_pix), .out_valid(ov1), .out_pix(op1)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic result(input int e0, input int e1, input string req);
      chk(ov0 == 1'b1, "R4", int'(ov0), 1);
      chk(ov1 == 1'b1, "R4", int'(ov1), 1);
      chk(int'(op0) == e0, req, int'(op0), e0);
      chk(int'(op1) == e1, req, int'(op1), e1);
   endtask

   // offer at a falling edge, accept on next rising edge, then count falling edges
   task automatic run_win(input logic [W-1:0] pix, input int e0, input int e1,
                          input string req);
      bit low_ok;
      @(negedge clk);
      chk(r0 == 1'b1, "R2", int'(r0), 1);
      win_valid = 1; win_pix = pix;
      @(negedge clk);
      win_valid = 0;
      low_ok = 1;
      for (int n = 1; n <= 8; n++) begin
         if (r0 || r1) low_ok = 0;
         if (n < 8) @(negedge clk);
      end
      chk(low_ok, "R3", int'(low_ok), 1);
      @(negedge clk);
      chk(r0 == 1'b1, "R5", int'(r0), 1);
      chk(ov0 == 1'b0, "R4", int'(ov0), 0);
      @(negedge clk);
      result(e0, e1, req);
      @(negedge clk);
      chk(ov0 == 1'b0, "R4", int'(ov0), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(ov0 == 1'b0, "R8", int'(ov0), 0);
      chk(r0 == 1'b1, "R8", int'(r0), 1);

      // R1 R6 R7 R9 table walk
      for (int i = 0; i < NV; i++)
         run_win(VECS[i].pix, int'(VECS[i].e0), int'(VECS[i].e1), "R1/R6/R7/R9");

      // R3: window offered while busy is ignored
      @(negedge clk);
      win_valid = 1; win_pix = one(12, 200);
      @(negedge clk);
      win_pix = {25{8'd255}};
      for (int n = 1; n < 8; n++) @(negedge clk);
      win_valid = 0;
      @(negedge clk);
      @(negedge clk);
      result(28, 255, "R3");

      // R5: back-to-back window accepted during step 8
      @(negedge clk);
      win_valid = 1; win_pix = one(12, 200);
      @(negedge clk);
      win_valid = 0;
      for (int n = 1; n < 9; n++) @(negedge clk);
      chk(r0 == 1'b1, "R5", int'(r0), 1);
      win_valid = 1; win_pix = one(24, 10);
      @(negedge clk);
      win_valid = 0;
      result(28, 255, "R5");
      for (int n = 0; n < 8; n++) @(negedge clk);
      chk(ov0 == 1'b0, "R5", int'(ov0), 0);
      @(negedge clk);
      result(0, 250, "R5");

      // R8: reset mid-computation abandons the window
      @(negedge clk);
      win_valid = 1; win_pix = {25{8'd100}};
      @(negedge clk);
      win_valid = 0;
      repeat (3) @(negedge clk);
      rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      begin
         bit quiet;
         quiet = 1;
         for (int n = 0; n < 14; n++) begin
            @(negedge clk);
            if (ov0 || ov1) quiet = 0;
         end
         chk(quiet, "R8", int'(quiet), 1);
      end
      chk(r0 == 1'b1, "R2", int'(r0), 1);

      run_win({25{8'd255}}, 255, 255, "R7");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule